// File: doc/BRIEF.md
# Serial Port Register Block with Triggered Receive Queue

This block is the register side of a memory-mapped serial port. A host reaches it over a plain one-operation-per-cycle read/write bus and finds a mode register, a control register, a transmit data register, a status register, a receive data register, a queue control register and a port register. Bytes handed in by an external deserialiser on a byte-valid strobe land in a 16-entry circular receive queue. Bytes written by the host leave on a byte-valid output strobe toward an external serialiser.

The receive-full status flag is tied to a trigger level chosen in the queue control register. When the queue fill reaches that level, the flag rises. If the receive interrupt is enabled, the receive interrupt line also rises. Status flags are cleared by writing 0 to them. Reading the status register while the transmitter is enabled sets the two transmit-empty flags again. Bit serialisation, baud timing and error or break interrupt routing are left to other blocks.

Register indices on `addr` are: 0 mode, 1 control, 2 transmit data, 3 status, 4 receive data, 5 queue control, 6 port. Read data appears on `rdata` one cycle after `rd_en`. A read is ignored when `wr_en` is high in the same cycle.

Top module: `sercom_regblk`

## Requirements
- R1: After reset, status reads 0x60 (transmit-end bit 6 and transmit-empty bit 5 set), control reads 0x20 (transmit-enable bit 5 set), mode, port and queue control read 0, and both interrupt outputs are low.
- R2: Written values are stored ANDed with 0x7B for mode, 0xFA for control and 0xF3 for port, and read back as stored.
- R3: A byte strobed on `rx_valid` is accepted only while control bit 4 is set and the queue holds fewer than 16 bytes, judged before any pop in the same cycle. Otherwise it is dropped. Reads of index 4 return accepted bytes in arrival order. A read of an empty queue returns 0 and changes nothing.
- R4: Queue control bits 7:6 select a trigger level: code 0 is 1 byte, 1 is 4, 2 is 8 and 3 is 14. When an accepted byte brings the fill to the level or above, status bit 1 (receive-full) is set.
- R5: When a pop leaves the fill below the trigger level, status bit 1 is cleared.
- R6: The event of R4 raises `irq_rx` when control bit 6, as it stands after any control write in the same cycle, is set.
- R7: A status write clears each of bits 6, 5, 4, 1 and 0 written as 0 and leaves those written as 1. Writing 0 to bit 1 or bit 0 drops `irq_rx`.
- R8: A control write with bit 5 clear sets transmit-end. `irq_tx` takes the written bit 7. Bit 6 written as 0 drops `irq_rx`.
- R9: A write to index 2 drives `tx_valid` high for exactly the next cycle with `tx_byte` equal to the written byte, and clears status bit 5.
- R10: A status read returns the flags as they stood. If control bit 5 is set, bits 5 and 6 are set again afterwards.
- R11: Writing queue control with bit 1 set empties the queue. A byte strobed in that same cycle is dropped, and the status flags are not touched.
- R12: When a flag-setting receive event (R4, R6, R13) falls in the same cycle as a status or control write that clears the same flag or interrupt, the set wins. A same-cycle accept and pop leave the fill unchanged.
- R13: `rx_break` sets status bit 4, and every accepted byte sets status bit 0 (data-ready).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 3 | Register index |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data, valid the cycle after rd_en |
| rx_valid | input | 1 | Incoming byte strobe |
| rx_byte | input | 8 | Incoming byte |
| rx_break | input | 1 | Line break detected pulse |
| tx_valid | output | 1 | Outgoing byte strobe |
| tx_byte | output | 8 | Outgoing byte |
| irq_rx | output | 1 | Receive interrupt |
| irq_tx | output | 1 | Transmit interrupt |

## Verification
The two functions that can meet in one cycle are a host register access and an incoming byte. This covers a pop landing with an accept, a status or control write clearing what an accept sets, and a queue clear landing with an accept. Directed steps force each of these pairings at full, trigger-edge and empty fills. Random steps then strobe bytes freely under random bus traffic. Every step is judged against a bench model that applies bus effects first and receive sets last, comparing read data, the transmit strobe and both interrupt lines.

// File: rtl/sercom_pkg.sv
package sercom_pkg;

    localparam logic [2:0] IDX_MODE = 3'd0;
    localparam logic [2:0] IDX_CTRL = 3'd1;
    localparam logic [2:0] IDX_TXD  = 3'd2;
    localparam logic [2:0] IDX_STAT = 3'd3;
    localparam logic [2:0] IDX_RXD  = 3'd4;
    localparam logic [2:0] IDX_QCTL = 3'd5;
    localparam logic [2:0] IDX_PORT = 3'd6;

    localparam logic [7:0] MASK_MODE = 8'h7B;
    localparam logic [7:0] MASK_CTRL = 8'hFA;
    localparam logic [7:0] MASK_PORT = 8'hF3;

    typedef struct packed {
        logic [7:0] mode;
        logic [7:0] ctrl;
        logic [7:0] port;
        logic [1:0] trig;
        logic       tend;
        logic       tde;
        logic       brk;
        logic       rdf;
        logic       dr;
        logic       irq_rx;
        logic       irq_tx;
        logic [7:0] rdata;
        logic       tx_valid;
        logic [7:0] tx_byte;
    } regs_t;

    function automatic int unsigned trig_level(logic [1:0] code);
        case (code)
            2'd0:    return 1;
            2'd1:    return 4;
            2'd2:    return 8;
            default: return 14;
        endcase
    endfunction

endpackage

// File: rtl/sercom_rxfifo.sv
module sercom_rxfifo #(
    parameter int DEPTH = 16,
    parameter int DW    = 8
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         push,
    input  logic                         pop,
    input  logic                         clr,
    input  logic [DW-1:0]                din,
    output logic [DW-1:0]                dout,
    output logic [$clog2(DEPTH+1)-1:0]   count
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);

    logic [DW-1:0] mem [DEPTH];
    logic [AW-1:0] head_d, head_q, tail_d, tail_q;
    logic [CW-1:0] cnt_d, cnt_q;

    function automatic logic [AW-1:0] wrap_inc(logic [AW-1:0] p);
        return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    always_comb begin
        head_d = head_q;
        tail_d = tail_q;
        cnt_d  = cnt_q;
        if (clr) begin
            head_d = '0;
            tail_d = '0;
            cnt_d  = '0;
        end else begin
            if (push) head_d = wrap_inc(head_q);
            if (pop)  tail_d = wrap_inc(tail_q);
            cnt_d = cnt_q + CW'(push) - CW'(pop);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            head_q <= '0;
            tail_q <= '0;
            cnt_q  <= '0;
        end else begin
            head_q <= head_d;
            tail_q <= tail_d;
            cnt_q  <= cnt_d;
        end
    end

    always_ff @(posedge clk) begin
        if (push && !clr) mem[head_q] <= din;
    end

    assign dout  = (cnt_q != '0) ? mem[tail_q] : '0;
    assign count = cnt_q;

    // R12: a simultaneous push and pop keeps the fill level
    a_r12_push_pop_level: assert property (@(posedge clk) disable iff (!rst_n)
        (push && pop && !clr) |=> $stable(cnt_q));

endmodule

// File: rtl/sercom_regblk.sv
module sercom_regblk
    import sercom_pkg::*;
#(
    parameter int DEPTH = 16
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr_en,
    input  logic       rd_en,
    input  logic [2:0] addr,
    input  logic [7:0] wdata,
    output logic [7:0] rdata,
    input  logic       rx_valid,
    input  logic [7:0] rx_byte,
    input  logic       rx_break,
    output logic       tx_valid,
    output logic [7:0] tx_byte,
    output logic       irq_rx,
    output logic       irq_tx
);
    localparam int CW = $clog2(DEPTH + 1);

    regs_t          d, q;
    logic           rd_go, push, pop, clr;
    logic [7:0]     ctrl_eff;
    logic [1:0]     trig_eff;
    logic [CW-1:0]  fifo_cnt, cnt_next, level;
    logic [7:0]     fifo_dout;
    logic [7:0]     stat_val;

    sercom_rxfifo #(.DEPTH(DEPTH), .DW(8)) u_rxq (
        .clk   (clk),
        .rst_n (rst_n),
        .push  (push),
        .pop   (pop),
        .clr   (clr),
        .din   (rx_byte),
        .dout  (fifo_dout),
        .count (fifo_cnt)
    );

    assign stat_val = {1'b0, q.tend, q.tde, q.brk, 2'b00, q.rdf, q.dr};

    always_comb begin
        d          = q;
        d.tx_valid = 1'b0;
        rd_go      = rd_en && !wr_en;
        ctrl_eff   = (wr_en && addr == IDX_CTRL) ? (wdata & MASK_CTRL) : q.ctrl;
        trig_eff   = (wr_en && addr == IDX_QCTL) ? wdata[7:6] : q.trig;
        clr        = wr_en && addr == IDX_QCTL && wdata[1];
        pop        = rd_go && addr == IDX_RXD && fifo_cnt != '0;
        push       = rx_valid && ctrl_eff[4] && (fifo_cnt < CW'(DEPTH)) && !clr;
        cnt_next   = clr ? '0 : fifo_cnt + CW'(push) - CW'(pop);
        level      = CW'(trig_level(trig_eff));

        // host writes
        if (wr_en) begin
            case (addr)
                IDX_MODE: d.mode = wdata & MASK_MODE;
                IDX_PORT: d.port = wdata & MASK_PORT;
                IDX_QCTL: d.trig = wdata[7:6];
                IDX_CTRL: begin
                    d.ctrl   = ctrl_eff;
                    if (!wdata[5]) d.tend = 1'b1;
                    d.irq_tx = wdata[7];
                    if (!wdata[6]) d.irq_rx = 1'b0;
                end
                IDX_TXD: begin
                    d.tx_valid = 1'b1;
                    d.tx_byte  = wdata;
                    d.tde      = 1'b0;
                end
                IDX_STAT: begin
                    d.tend = q.tend & wdata[6];
                    d.tde  = q.tde  & wdata[5];
                    d.brk  = q.brk  & wdata[4];
                    d.rdf  = q.rdf  & wdata[1];
                    d.dr   = q.dr   & wdata[0];
                    if (!wdata[1] || !wdata[0]) d.irq_rx = 1'b0;
                end
                default: ;
            endcase
        end

        // host reads
        if (rd_go) begin
            case (addr)
                IDX_MODE: d.rdata = q.mode;
                IDX_CTRL: d.rdata = q.ctrl;
                IDX_STAT: d.rdata = stat_val;
                IDX_RXD:  d.rdata = fifo_dout;
                IDX_QCTL: d.rdata = {q.trig, 6'b0};
                IDX_PORT: d.rdata = q.port;
                default:  d.rdata = 8'h00;
            endcase
            if (addr == IDX_STAT && q.ctrl[5]) begin
                d.tde  = 1'b1;
                d.tend = 1'b1;
            end
        end

        // receive side events, applied last so that sets win
        if (pop && cnt_next < level) d.rdf = 1'b0;
        if (push) begin
            d.dr = 1'b1;
            if (cnt_next >= level) begin
                d.rdf = 1'b1;
                if (ctrl_eff[6]) d.irq_rx = 1'b1;
            end
        end
        if (rx_break) d.brk = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q      <= '0;
            q.ctrl <= 8'h20;
            q.tend <= 1'b1;
            q.tde  <= 1'b1;
        end else begin
            q <= d;
        end
    end

    assign rdata    = q.rdata;
    assign tx_valid = q.tx_valid;
    assign tx_byte  = q.tx_byte;
    assign irq_rx   = q.irq_rx;
    assign irq_tx   = q.irq_tx;

    // R9: an outgoing strobe always traces back to a transmit data write
    a_r9_tx_from_write: assert property (@(posedge clk) disable iff (!rst_n)
        tx_valid |-> $past(wr_en && addr == IDX_TXD));

    // R6: the receive interrupt only rises on a cycle that delivered a byte
    a_r6_irq_needs_byte: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_rx) |-> $past(rx_valid));

    // R3: a full queue never grows and drops the extra byte
    a_r3_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        (fifo_cnt == CW'(DEPTH) && !pop && !clr) |=> fifo_cnt == CW'(DEPTH));

    // R3: reading an empty queue yields zero
    a_r3_empty_read_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && !wr_en && addr == IDX_RXD && fifo_cnt == '0) |=> rdata == 8'h00);

    // R10: a status read with the transmitter enabled restores both empty flags
    a_r10_status_refill: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && !wr_en && addr == IDX_STAT && q.ctrl[5]) |=> (q.tde && q.tend));

endmodule

// File: tb/sercom_regblk_tb.sv
module sercom_regblk_tb;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0, rd_en = 1'b0, rx_valid = 1'b0, rx_break = 1'b0;
    logic [2:0] addr = '0;
    logic [7:0] wdata = '0, rx_byte = '0;
    logic [7:0] rdata, tx_byte;
    logic       tx_valid, irq_rx, irq_tx;

    int n_chk = 0;
    int n_err = 0;

    // bench model
    logic [7:0] m_mode, m_ctrl, m_port;
    logic [1:0] m_trig;
    logic       m_tend, m_tde, m_brk, m_rdf, m_dr, m_irx, m_itx;
    logic [7:0] mq[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    sercom_regblk u_dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
        .wdata(wdata), .rdata(rdata), .rx_valid(rx_valid), .rx_byte(rx_byte),
        .rx_break(rx_break), .tx_valid(tx_valid), .tx_byte(tx_byte),
        .irq_rx(irq_rx), .irq_tx(irq_tx)
    );

    function automatic int lvl_of(logic [1:0] c);
        return (c == 2'd0) ? 1 : (c == 2'd1) ? 4 : (c == 2'd2) ? 8 : 14;
    endfunction

    function automatic logic [7:0] stat_of();
        return {1'b0, m_tend, m_tde, m_brk, 2'b00, m_rdf, m_dr};
    endfunction

    task automatic chk(string tag, logic [7:0] act, logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual 0x%02h expected 0x%02h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic model_reset();
        m_mode = 0; m_ctrl = 8'h20; m_port = 0; m_trig = 0;
        m_tend = 1; m_tde = 1; m_brk = 0; m_rdf = 0; m_dr = 0;
        m_irx = 0; m_itx = 0;
        mq.delete();
    endtask

    // one clock step; called at a falling edge, returns at the next falling edge
    task automatic step(bit w, bit r, logic [2:0] a, logic [7:0] dv,
                        bit rv, logic [7:0] rb, bit bk, string tag);
        logic [7:0] ce, exp_rd;
        logic [1:0] te;
        bit clr, pop, push, exp_tx;
        int sz0, n;
        wr_en = w; rd_en = r; addr = a; wdata = dv;
        rx_valid = rv; rx_byte = rb; rx_break = bk;

        ce  = (w && a == 3'd1) ? (dv & 8'hFA) : m_ctrl;
        te  = (w && a == 3'd5) ? dv[7:6] : m_trig;
        clr = w && a == 3'd5 && dv[1];
        sz0 = mq.size();
        r   = r && !w;
        exp_rd = 8'h00;
        if (r) begin
            case (a)
                3'd0: exp_rd = m_mode;
                3'd1: exp_rd = m_ctrl;
                3'd3: exp_rd = stat_of();
                3'd4: exp_rd = (sz0 > 0) ? mq[0] : 8'h00;
                3'd5: exp_rd = {m_trig, 6'b0};
                3'd6: exp_rd = m_port;
                default: exp_rd = 8'h00;
            endcase
        end
        pop    = r && a == 3'd4 && sz0 > 0;
        exp_tx = w && a == 3'd2;
        if (w) begin
            case (a)
                3'd0: m_mode = dv & 8'h7B;
                3'd6: m_port = dv & 8'hF3;
                3'd1: begin
                    if (!dv[5]) m_tend = 1;
                    m_itx = dv[7];
                    if (!dv[6]) m_irx = 0;
                end
                3'd2: m_tde = 0;
                3'd3: begin
                    m_tend &= dv[6]; m_tde &= dv[5]; m_brk &= dv[4];
                    m_rdf &= dv[1]; m_dr &= dv[0];
                    if (!dv[1] || !dv[0]) m_irx = 0;
                end
                default: ;
            endcase
        end
        if (r && a == 3'd3 && m_ctrl[5]) begin m_tend = 1; m_tde = 1; end
        m_ctrl = ce; m_trig = te;
        if (pop) void'(mq.pop_front());
        if (clr) mq.delete();
        push = rv && ce[4] && sz0 < 16 && !clr;
        if (push) begin mq.push_back(rb); m_dr = 1; end
        n = mq.size();
        if (pop && n < lvl_of(te)) m_rdf = 0;
        if (push && n >= lvl_of(te)) begin
            m_rdf = 1;
            if (ce[6]) m_irx = 1;
        end
        if (bk) m_brk = 1;

        @(negedge clk);
        if (r) chk(tag, rdata, exp_rd);
        chk("R9 tx_valid", {7'b0, tx_valid}, {7'b0, exp_tx});
        if (exp_tx) chk("R9 tx_byte", tx_byte, dv);
        chk("R6 irq_rx", {7'b0, irq_rx}, {7'b0, m_irx});
        chk("R8 irq_tx", {7'b0, irq_tx}, {7'b0, m_itx});
        wr_en = 0; rd_en = 0; rx_valid = 0; rx_break = 0;
    endtask

    task automatic finish_sim();
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++; n_err++;
        $display("FAIL watchdog: actual hung expected done");
        finish_sim();
    end

    initial begin
        void'($urandom(32'd4711));
        model_reset();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset values
        step(0,1,3,0,0,0,0,"R1 status");
        chk("R1 status literal", rdata, 8'h60);
        step(0,1,1,0,0,0,0,"R1 ctrl");
        chk("R1 ctrl literal", rdata, 8'h20);
        step(0,1,0,0,0,0,0,"R1 mode");
        step(0,1,5,0,0,0,0,"R1 qctl");

        // R2: masks
        step(1,0,0,8'hFF,0,0,0,"R2");  step(0,1,0,0,0,0,0,"R2 mode");
        chk("R2 mode literal", rdata, 8'h7B);
        step(1,0,6,8'hFF,0,0,0,"R2");  step(0,1,6,0,0,0,0,"R2 port");
        step(1,0,1,8'hFF,0,0,0,"R8");  step(0,1,1,0,0,0,0,"R2 ctrl");
        chk("R2 ctrl literal", rdata, 8'hFA);

        // R8 / R9 / R10: transmit side
        step(1,0,1,8'h00,0,0,0,"R8");
        step(1,0,2,8'hA5,0,0,0,"R9");
        step(0,1,3,0,0,0,0,"R10 status no refill");
        step(1,0,1,8'h30,0,0,0,"R8");
        step(1,0,2,8'h3C,0,0,0,"R9");
        step(0,1,3,0,0,0,0,"R10 status old value");
        step(0,1,3,0,0,0,0,"R10 status refilled");
        chk("R10 refilled literal", rdata, 8'h60);

        // R3 / R4 / R5 / R6: fill past 16 with trigger code 3 (14)
        step(1,0,1,8'h70,0,0,0,"R8");
        step(1,0,5,8'hC0,0,0,0,"R4");
        for (int i = 0; i < 17; i++) step(0,0,0,0,1,8'(i+8'h40),0,"R3");
        step(0,1,3,0,0,0,0,"R4 status full");
        for (int i = 0; i < 3; i++) step(0,1,4,0,0,0,0,"R3 order");
        step(0,1,3,0,0,0,0,"R5 status after drop");
        // R12: pop and accept together at the trigger edge
        step(0,1,4,0,1,8'h99,0,"R12 pop+push");
        // R12: status clear against an accept that sets
        step(1,0,3,8'h00,1,8'h77,0,"R12 clear vs set");
        step(0,1,3,0,0,0,0,"R12 status");
        // R11: clear with a colliding byte
        step(1,0,5,8'h02,1,8'h55,0,"R11");
        step(0,1,4,0,0,0,0,"R3 empty read");
        chk("R3 empty literal", rdata, 8'h00);
        step(0,1,3,0,0,0,0,"R11 flags kept");
        // R13: break and data-ready
        step(1,0,3,8'h00,0,0,1,"R13");
        step(0,1,3,0,0,0,0,"R13 status");
        // R4: each trigger code
        for (int c = 0; c < 4; c++) begin
            step(1,0,5,{2'(c),6'b000010},0,0,0,"R4");
            step(1,0,3,8'h00,0,0,0,"R7");
            for (int k = 0; k < 15; k++) begin
                step(0,0,0,0,1,8'(k),0,"R4");
                step(0,1,3,0,0,0,0,"R4 level");
            end
        end
        // R8: control write dropping receive interrupt while a byte lands
        step(1,0,1,8'h10,1,8'h11,0,"R8 ctrl vs byte");
        // R3: receive disabled drops bytes
        step(1,0,5,8'h02,0,0,0,"R11");
        step(1,0,1,8'h60,1,8'h22,0,"R3");
        step(0,1,4,0,0,0,0,"R3 disabled");

        // random phase
        for (int i = 0; i < 6000; i++) begin
            int op;
            logic [7:0] dv;
            logic [2:0] a;
            op = $urandom_range(0, 9);
            dv = 8'($urandom);
            a  = 3'($urandom_range(0, 6));
            if (a == 3'd5 && $urandom_range(0, 7) != 0) dv[1] = 1'b0;
            if (a == 3'd1 && $urandom_range(0, 3) != 0) dv[4] = 1'b1;
            if (op < 3)      step(1,0,a,dv,$urandom_range(0,1) != 0,8'($urandom),$urandom_range(0,31)==0,"R7 rand");
            else if (op < 7) step(0,1,a,0,$urandom_range(0,1) != 0,8'($urandom),0,"R3 rand read");
            else             step(0,0,0,0,$urandom_range(0,2) != 0,8'($urandom),0,"R12 rand");
        end

        finish_sim();
    end
endmodule